// File: doc/BRIEF.md
# Compact Register-Format Extend and Jump Unit

This unit executes one class of 16-bit compact instructions: the register-format group whose major opcode is `11101`. Each accepted word names one register through a 3-bit field. Depending on its sub-operation and function fields, the unit does one of two things:

- It sign-extends or zero-extends that register in place from 8, 16 or 32 bits.
- It produces a jump target with no delay slot, taken from that register or from the return-address register. The jump may optionally store the next instruction address into the return-address register.

The host pipeline drives a valid strobe with the instruction word, the next instruction address and a flag that enables 64-bit operation. It serves one combinational register read port. One clock later it receives a registered write-back, a redirect, an illegal-instruction flag and a one-cycle completion pulse. Words with a different major opcode are not this unit's business and produce no response.

Top module: `cmpx_rr_unit`

## Requirements
- R1: While and after synchronous reset, and with no instruction presented, `done`, `illegal`, `rf_we` and `redirect_valid` are all low.
- R2: The word is laid out as major opcode in bits 15:11, register selector in bits 10:8, sub-operation in bits 7:5 and function in bits 4:0. Selector codes 0 and 1 address registers 16 and 17. Codes 2 to 7 address registers 2 to 7. An extend writes its result back to the register it read.
- R3: Function `10001` with sub-operation `100` writes the register sign-extended from bit 7. Sub-operation `101` sign-extends from bit 15.
- R4: Function `10001` with sub-operation `000` writes the register with all bits above bit 7 cleared. Sub-operation `001` clears all bits above bit 15.
- R5: With `wide_mode` = 1, function `10001` has two further forms. Sub-operation `110` sign-extends from bit 31. Sub-operation `010` clears all bits above bit 31.
- R6: With `wide_mode` = 0, those two 32-bit forms raise `illegal` and produce no write-back.
- R7: Function `00000` with sub-operation `100` redirects to the selected register's value and writes no register.
- R8: Function `00000` with sub-operation `101` and selector `000` redirects to the value of register 31. With any other selector value this form is illegal.
- R9: Function `00000` with sub-operation `110` writes `nia` into register 31 and redirects to the selected register's value, in the same cycle.
- R10: Every other sub-operation and function pair under this major opcode raises `illegal`, with no write-back and no redirect.
- R11: Results appear on the clock edge after the valid strobe, together with a one-cycle `done` pulse. A word with another major opcode, or a word presented without the strobe, produces no `done`, no `illegal`, no write and no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 16 | Compact instruction word |
| wide_mode | input | 1 | 64-bit operation enabled |
| nia | input | XLEN | Address of the next instruction |
| rf_raddr | output | 5 | Register file read address (combinational) |
| rf_rdata | input | XLEN | Register file read data (combinational) |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write address |
| rf_wdata | output | XLEN | Register write data |
| redirect_valid | output | 1 | Fetch must continue at `redirect_target` |
| redirect_target | output | XLEN | Jump target address |
| illegal | output | 1 | Instruction is not a legal form |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is the mode-dependent trap. The same 32-bit extend word must write back when `wide_mode` is high and trap when it is low. The stimulus therefore issues the identical word under both settings and checks that the register is not written in the trapping case. The linking jump is also delicate, because it carries a write and a redirect in the same cycle with different sources. The bench gives `nia`, register 31 and the selected register three distinct values, so a swapped source shows up in the comparison.

// File: rtl/cmpx_pkg.sv
package cmpx_pkg;

    localparam logic [4:0] MAJOR_RR = 5'b11101;
    localparam logic [4:0] FN_EXT   = 5'b10001;
    localparam logic [4:0] FN_JMP   = 5'b00000;
    localparam logic [4:0] RA_IDX   = 5'd31;

    // Field order matches bit positions of the 16-bit word
    typedef struct packed {
        logic [4:0] major;
        logic [2:0] rsel;
        logic [2:0] sub;
        logic [4:0] fn;
    } rr_word_t;

    typedef enum logic [2:0] {
        K_NONE,
        K_EXT,
        K_JR,
        K_JRRA,
        K_JALR,
        K_ILL
    } kind_e;

    typedef enum logic [1:0] {
        W_BYTE,
        W_HALF,
        W_WORD
    } ext_width_e;

    typedef struct packed {
        kind_e      kind;
        logic       ext_signed;
        ext_width_e width;
        logic [4:0] src;
    } dec_t;

    // 3-bit selector to architectural register index
    function automatic logic [4:0] map_reg(input logic [2:0] sel);
        if (sel < 3'd2) return {4'b1000, sel[0]};
        else            return {2'b00, sel};
    endfunction

    function automatic int top_bit(input ext_width_e w);
        case (w)
            W_BYTE:  return 7;
            W_HALF:  return 15;
            default: return 31;
        endcase
    endfunction

endpackage

// File: rtl/cmpx_decode.sv
module cmpx_decode
    import cmpx_pkg::*;
#(
    parameter bit WIDE_OK = 1'b1
) (
    input  logic     valid,
    input  rr_word_t word,
    input  logic     wide_mode,
    output dec_t     dec
);

    logic wide_legal;
    assign wide_legal = WIDE_OK && wide_mode;

    always_comb begin
        dec.kind       = K_NONE;
        dec.ext_signed = 1'b0;
        dec.width      = W_BYTE;
        dec.src        = map_reg(word.rsel);
        if (valid && word.major == MAJOR_RR) begin
            dec.kind = K_ILL;
            case (word.fn)
                FN_EXT: begin
                    case (word.sub)
                        3'b100: begin dec.kind = K_EXT; dec.ext_signed = 1'b1; dec.width = W_BYTE; end
                        3'b101: begin dec.kind = K_EXT; dec.ext_signed = 1'b1; dec.width = W_HALF; end
                        3'b000: begin dec.kind = K_EXT; dec.ext_signed = 1'b0; dec.width = W_BYTE; end
                        3'b001: begin dec.kind = K_EXT; dec.ext_signed = 1'b0; dec.width = W_HALF; end
                        3'b110: if (wide_legal) begin
                            dec.kind = K_EXT; dec.ext_signed = 1'b1; dec.width = W_WORD;
                        end
                        3'b010: if (wide_legal) begin
                            dec.kind = K_EXT; dec.ext_signed = 1'b0; dec.width = W_WORD;
                        end
                        default: dec.kind = K_ILL;
                    endcase
                end
                FN_JMP: begin
                    case (word.sub)
                        3'b100: dec.kind = K_JR;
                        3'b101: if (word.rsel == 3'b000) begin
                            dec.kind = K_JRRA;
                            dec.src  = RA_IDX;
                        end
                        3'b110: dec.kind = K_JALR;
                        default: dec.kind = K_ILL;
                    endcase
                end
                default: dec.kind = K_ILL;
            endcase
        end
    end

endmodule

// File: rtl/cmpx_extend.sv
module cmpx_extend
    import cmpx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] value,
    input  ext_width_e      width,
    input  logic            is_signed,
    output logic [XLEN-1:0] result
);

    localparam int TB_MAX = (XLEN > 32) ? 31 : XLEN - 1;

    int   tb;
    logic fill;

    always_comb begin
        tb = top_bit(width);
        if (tb > TB_MAX) tb = TB_MAX;
        fill = is_signed & value[tb];
        for (int i = 0; i < XLEN; i++) begin
            result[i] = (i <= tb) ? value[i] : fill;
        end
    end

endmodule

// File: rtl/cmpx_commit.sv
module cmpx_commit
    import cmpx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  dec_t            dec,
    input  logic [XLEN-1:0] ext_result,
    input  logic [XLEN-1:0] src_value,
    input  logic [XLEN-1:0] nia,
    output logic            rf_we,
    output logic [4:0]      rf_waddr,
    output logic [XLEN-1:0] rf_wdata,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_target,
    output logic            illegal,
    output logic            done
);

    logic is_jump;
    logic is_write;
    assign is_jump  = (dec.kind == K_JR) || (dec.kind == K_JRRA) || (dec.kind == K_JALR);
    assign is_write = (dec.kind == K_EXT) || (dec.kind == K_JALR);

    always_ff @(posedge clk) begin
        if (rst) begin
            rf_we           <= 1'b0;
            rf_waddr        <= '0;
            rf_wdata        <= '0;
            redirect_valid  <= 1'b0;
            redirect_target <= '0;
            illegal         <= 1'b0;
            done            <= 1'b0;
        end else begin
            done           <= dec.kind != K_NONE;
            illegal        <= dec.kind == K_ILL;
            rf_we          <= is_write;
            redirect_valid <= is_jump;
            if (dec.kind == K_JALR) begin
                rf_waddr <= RA_IDX;
                rf_wdata <= nia;
            end else if (dec.kind == K_EXT) begin
                rf_waddr <= dec.src;
                rf_wdata <= ext_result;
            end
            if (is_jump) redirect_target <= src_value;
        end
    end

    // R10: a trap never writes or redirects
    p_trap_silent_r10: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!rf_we && !redirect_valid));

endmodule

// File: rtl/cmpx_rr_unit.sv
module cmpx_rr_unit
    import cmpx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_valid,
    input  logic [15:0]     instr_word,
    input  logic            wide_mode,
    input  logic [XLEN-1:0] nia,
    output logic [4:0]      rf_raddr,
    input  logic [XLEN-1:0] rf_rdata,
    output logic            rf_we,
    output logic [4:0]      rf_waddr,
    output logic [XLEN-1:0] rf_wdata,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_target,
    output logic            illegal,
    output logic            done
);

    localparam bit WIDE_OK = XLEN > 32;

    rr_word_t        word;
    dec_t            dec;
    logic [XLEN-1:0] ext_result;

    assign word     = rr_word_t'(instr_word);
    assign rf_raddr = dec.src;

    cmpx_decode #(.WIDE_OK(WIDE_OK)) u_decode (
        .valid     (instr_valid),
        .word      (word),
        .wide_mode (wide_mode),
        .dec       (dec)
    );

    cmpx_extend #(.XLEN(XLEN)) u_extend (
        .value     (rf_rdata),
        .width     (dec.width),
        .is_signed (dec.ext_signed),
        .result    (ext_result)
    );

    cmpx_commit #(.XLEN(XLEN)) u_commit (
        .clk             (clk),
        .rst             (rst),
        .dec             (dec),
        .ext_result      (ext_result),
        .src_value       (rf_rdata),
        .nia             (nia),
        .rf_we           (rf_we),
        .rf_waddr        (rf_waddr),
        .rf_wdata        (rf_wdata),
        .redirect_valid  (redirect_valid),
        .redirect_target (redirect_target),
        .illegal         (illegal),
        .done            (done)
    );

    logic ours;
    assign ours = instr_valid && (instr_word[15:11] == MAJOR_RR);

    // R11: accepted word completes on the next edge
    p_done_next_r11: assert property (@(posedge clk) disable iff (rst)
        ours |=> done);

    // R11: foreign or absent words leave every output quiet
    p_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !ours |=> (!done && !illegal && !rf_we && !redirect_valid));

    // R6: narrow mode traps the 32-bit extend forms
    p_wide_trap_r6: assert property (@(posedge clk) disable iff (rst)
        (ours && !wide_mode && instr_word[4:0] == FN_EXT && instr_word[6:5] == 2'b10)
        |=> (illegal && !rf_we));

    // R9: link writes next address to the return register
    p_link_r9: assert property (@(posedge clk) disable iff (rst)
        (rf_we && redirect_valid) |-> (rf_waddr == RA_IDX && rf_wdata == $past(nia)));

    // R7: target is the value read in the issuing cycle
    p_target_r7: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> (redirect_target == $past(rf_rdata)));

    // R2: extend writes the register it read
    p_inplace_r2: assert property (@(posedge clk) disable iff (rst)
        (rf_we && !redirect_valid) |-> (rf_waddr == $past(rf_raddr)));

endmodule

// File: tb/cmpx_rr_unit_tb.sv
module cmpx_rr_unit_tb;

    localparam int XLEN   = 64;
    localparam int CLK_NS = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            instr_valid = 1'b0;
    logic [15:0]     instr_word = '0;
    logic            wide_mode = 1'b0;
    logic [XLEN-1:0] nia = '0;
    logic [4:0]      rf_raddr;
    logic [XLEN-1:0] rf_rdata;
    logic            rf_we;
    logic [4:0]      rf_waddr;
    logic [XLEN-1:0] rf_wdata;
    logic            redirect_valid;
    logic [XLEN-1:0] redirect_target;
    logic            illegal;
    logic            done;

    logic [XLEN-1:0] regs [32];
    assign rf_rdata = regs[rf_raddr];

    int total = 0;
    int bad   = 0;

    always #(CLK_NS/2) clk = ~clk;

    cmpx_rr_unit #(.XLEN(XLEN)) u_dut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .wide_mode(wide_mode), .nia(nia), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .redirect_valid(redirect_valid), .redirect_target(redirect_target),
        .illegal(illegal), .done(done)
    );

    function automatic logic [15:0] mk(input logic [2:0] rsel, input logic [2:0] sub,
                                       input logic [4:0] fn);
        return {5'b11101, rsel, sub, fn};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // present one word for one cycle; returns at the negedge where results are visible
    task automatic issue(input logic [15:0] w, input logic wide, input logic [XLEN-1:0] n);
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = w;
        wide_mode   = wide;
        nia         = n;
        @(negedge clk);
        instr_valid = 1'b0;
        instr_word  = '0;
    endtask

    task automatic t_reset();
        chk("R1 done",     64'(done), 0);
        chk("R1 illegal",  64'(illegal), 0);
        chk("R1 rf_we",    64'(rf_we), 0);
        chk("R1 redirect", 64'(redirect_valid), 0);
    endtask

    task automatic t_sign();
        regs[16] = 64'h1234_5678_9ABC_DE80;
        issue(mk(3'd0, 3'b100, 5'b10001), 1'b0, '0);
        chk("R3 byte sign data", rf_wdata, 64'hFFFF_FFFF_FFFF_FF80);
        chk("R2 sel0 -> reg16",  64'(rf_waddr), 16);
        chk("R3 we",             64'(rf_we), 1);
        chk("R3 no redirect",    64'(redirect_valid), 0);
        regs[17] = 64'hFFFF_FFFF_FFFF_7FFF;
        issue(mk(3'd1, 3'b101, 5'b10001), 1'b0, '0);
        chk("R3 half sign data", rf_wdata, 64'h0000_0000_0000_7FFF);
        chk("R2 sel1 -> reg17",  64'(rf_waddr), 17);
    endtask

    task automatic t_zero();
        regs[5] = 64'hFFFF_FFFF_FFFF_FFA5;
        issue(mk(3'd5, 3'b000, 5'b10001), 1'b0, '0);
        chk("R4 byte zero data", rf_wdata, 64'h0000_0000_0000_00A5);
        chk("R2 sel5 -> reg5",   64'(rf_waddr), 5);
        regs[2] = 64'h8000_0000_0000_C3C3;
        issue(mk(3'd2, 3'b001, 5'b10001), 1'b0, '0);
        chk("R4 half zero data", rf_wdata, 64'h0000_0000_0000_C3C3);
        chk("R4 illegal low",    64'(illegal), 0);
    endtask

    task automatic t_word_wide();
        regs[3] = 64'h0000_0000_8000_0001;
        issue(mk(3'd3, 3'b110, 5'b10001), 1'b1, '0);
        chk("R5 word sign data", rf_wdata, 64'hFFFF_FFFF_8000_0001);
        chk("R5 word sign we",   64'(rf_we), 1);
        regs[4] = 64'hFFFF_FFFF_8000_0001;
        issue(mk(3'd4, 3'b010, 5'b10001), 1'b1, '0);
        chk("R5 word zero data", rf_wdata, 64'h0000_0000_8000_0001);
        chk("R5 word zero addr", 64'(rf_waddr), 4);
    endtask

    task automatic t_word_narrow();
        issue(mk(3'd3, 3'b110, 5'b10001), 1'b0, '0);
        chk("R6 sign trap",   64'(illegal), 1);
        chk("R6 sign no we",  64'(rf_we), 0);
        issue(mk(3'd4, 3'b010, 5'b10001), 1'b0, '0);
        chk("R6 zero trap",   64'(illegal), 1);
        chk("R6 zero no we",  64'(rf_we), 0);
    endtask

    task automatic t_jr();
        regs[6] = 64'h0000_0000_0040_1000;
        issue(mk(3'd6, 3'b100, 5'b00000), 1'b0, 64'h55);
        chk("R7 redirect",  64'(redirect_valid), 1);
        chk("R7 target",    redirect_target, 64'h0000_0000_0040_1000);
        chk("R7 no write",  64'(rf_we), 0);
    endtask

    task automatic t_jrra();
        regs[31] = 64'h0000_0000_0077_2220;
        regs[16] = 64'h0000_0000_0000_0BAD;
        issue(mk(3'd0, 3'b101, 5'b00000), 1'b0, 64'h66);
        chk("R8 redirect",  64'(redirect_valid), 1);
        chk("R8 target ra", redirect_target, 64'h0000_0000_0077_2220);
        chk("R8 no write",  64'(rf_we), 0);
        issue(mk(3'd3, 3'b101, 5'b00000), 1'b0, 64'h66);
        chk("R8 bad sel trap",     64'(illegal), 1);
        chk("R8 bad sel no jump",  64'(redirect_valid), 0);
    endtask

    task automatic t_jalr();
        regs[7]  = 64'h0000_0000_0090_0040;
        regs[31] = 64'h0000_0000_0000_1111;
        issue(mk(3'd7, 3'b110, 5'b00000), 1'b0, 64'h0000_0000_4000_0010);
        chk("R9 write",     64'(rf_we), 1);
        chk("R9 link addr", 64'(rf_waddr), 31);
        chk("R9 link data", rf_wdata, 64'h0000_0000_4000_0010);
        chk("R9 redirect",  64'(redirect_valid), 1);
        chk("R9 target",    redirect_target, 64'h0000_0000_0090_0040);
    endtask

    task automatic t_illegal();
        logic [15:0] words [4];
        words[0] = mk(3'd2, 3'b111, 5'b10001);
        words[1] = mk(3'd2, 3'b011, 5'b10001);
        words[2] = mk(3'd2, 3'b000, 5'b00000);
        words[3] = mk(3'd2, 3'b100, 5'b00001);
        for (int i = 0; i < 4; i++) begin
            issue(words[i], 1'b1, '0);
            chk("R10 illegal",     64'(illegal), 1);
            chk("R10 no write",    64'(rf_we), 0);
            chk("R10 no redirect", 64'(redirect_valid), 0);
            chk("R10 done",        64'(done), 1);
        end
    endtask

    task automatic t_timing();
        regs[16] = 64'h0000_0000_0000_0080;
        issue(mk(3'd0, 3'b100, 5'b10001), 1'b0, '0);
        chk("R11 done pulse", 64'(done), 1);
        @(negedge clk);
        chk("R11 done drops", 64'(done), 0);
        chk("R11 we drops",   64'(rf_we), 0);
        issue({5'b11100, 3'd0, 3'b100, 5'b10001}, 1'b0, '0);
        chk("R11 foreign no done", 64'(done), 0);
        chk("R11 foreign no we",   64'(rf_we), 0);
        chk("R11 foreign no trap", 64'(illegal), 0);
        @(negedge clk);
        instr_word = mk(3'd6, 3'b100, 5'b00000);
        @(negedge clk);
        chk("R11 no strobe no done",   64'(done), 0);
        chk("R11 no strobe no jump",   64'(redirect_valid), 0);
        instr_word = '0;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = {8{8'(i)}};
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sign();
        t_zero();
        t_word_wide();
        t_word_narrow();
        t_jr();
        t_jrra();
        t_jalr();
        t_illegal();
        t_timing();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_NS * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule